// File: doc/BRIEF.md
# Monochrome Hardware Cursor Overlay

This block merges a 64x64 two-plane cursor image into a stream of screen pixels. Software programs a small set of registers: a cursor base address in video memory together with a lock flag, a packed X/Y screen position, two 24-bit cursor colours, an enable bit and the visible display geometry. Once per frame, while the lock is clear, the programmed position, base address and enable are copied into an active set that drives the drawing for the whole frame. This prevents tearing when software updates the cursor mid-frame.

Before each scanline (during horizontal blanking) the display pipeline pulses a fetch request with the row about to be shown. If that row falls inside the cursor window, the block reads the 16-byte mask line for that row from video memory into a 128-bit line buffer. During the visible part of the line, every incoming pixel leaves one cycle later. It is either untouched, replaced by a cursor colour, or inverted, as the AND/XOR mask bit pair for that position selects.

Top module: `cursor_overlay`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `pix_out_valid`, `mem_rd_en` and `pix_out` are all zero.
- R2: Each pixel presented with `pix_valid` appears on `pix_out` with `pix_out_valid` exactly one clock later. Pixels not covered by the cursor are output unchanged.
- R3: A covered pixel whose AND bit is 0 outputs colour 1 when its XOR bit is 1 and colour 0 when its XOR bit is 0. Bits 31:24 of the output are forced to 0xFF and bits 23:0 carry the colour.
- R4: A covered pixel whose AND bit is 1 outputs the bitwise complement of the 32-bit input pixel when its XOR bit is 1, and the input pixel unchanged when its XOR bit is 0.
- R5: A row is drawn only when the active enable is set, the row lies in [cursor_y, cursor_y+64), and the row is not greater than the programmed last display row.
- R6: Within a drawn row, a pixel is covered only when its x lies in [cursor_x, cursor_x+64) and x is below the programmed display width. The cursor never spills onto another line.
- R7: For a drawn row n = row - cursor_y, the block issues 128/MEM_W consecutive reads (one per cycle) starting at base + 16*n and stepping by MEM_W/8 bytes. Read data returns one cycle after `mem_rd_en` and is little-endian: byte k of the line sits at address base+16n+k. Bytes 0..7 are the AND mask and bytes 8..15 the XOR mask. Within each byte, bit 7 is the leftmost pixel, so cursor column c uses byte c/8, bit 7-(c mod 8).
- R8: Register writes (`reg_addr` values) behave as follows. Address 0 (base) keeps bits 26:4 of the data as the base address, clears bits 3:0 and ignores bits 30:27. Address 1 (position) takes X from bits 29:16 and Y from bits 11:0 and ignores bits 30 and 15:12. Addresses 2 and 3 (colour 0 and colour 1) keep bits 23:0. Address 4 takes the enable from bit 0. Address 5 takes the display width in pixels from bits 15:0 and the last display row from bits 31:16.
- R9: Bit 31 of a write to address 0 or 1 becomes the lock flag, whether it is 1 or 0. While the lock is set, a frame start leaves the active position, base address and enable unchanged.
- R10: The active position, base address and enable change only on a `frame_start` pulse with the lock clear. Writes made during a frame take effect from the next unlocked frame start. Colours and geometry take effect at once.
- R11: A fetch request for a row that is not drawn issues no memory read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| frame_start | input | 1 | One-cycle pulse at the start of each frame |
| fetch_req | input | 1 | One-cycle pulse in horizontal blanking requesting the mask line |
| fetch_y | input | 16 | Screen row of the upcoming line |
| pix_valid | input | 1 | Input pixel valid |
| pix_x | input | 16 | Screen column of the input pixel |
| pix_y | input | 16 | Screen row of the input pixel |
| pix_in | input | 32 | Input screen pixel |
| pix_out_valid | output | 1 | Output pixel valid |
| pix_out | output | 32 | Merged output pixel |
| mem_rd_en | output | 1 | Video memory read strobe |
| mem_addr | output | 27 | Byte address of the read |
| mem_rdata | input | MEM_W | Read data, one cycle after the strobe |

## Verification
The bench sweeps whole frames pixel by pixel. It places the cursor against the left screen edge, across the right clipping edge and across the last display row. A design that let the cursor run past the width would corrupt pixels at the right of the screen, and one that ignored the last row would draw into lines below the display. The bench also moves the cursor while locked, mid-frame and while disabled. Wrong latching would show the cursor at the new spot too early, or the old one too long. The memory model's bytes are a hash of their address, so a mis-masked base, a wrong row stride or a reversed bit order changes the pixels seen. Read counts per line catch fetches issued for invisible rows.

// File: rtl/cursor_pkg.sv
`timescale 1ns/1ps
package cursor_pkg;
    localparam int CUR_DIM    = 64;
    localparam int LINE_BYTES = 16;
    localparam int LINE_BITS  = LINE_BYTES * 8;
    localparam int OFF_W      = 27;
    localparam int XPOS_W     = 14;
    localparam int YPOS_W     = 12;
    localparam int COORD_W    = 16;
    localparam int COLOR_W    = 24;
    localparam int LOCK_BIT   = 31;
    localparam int BASE_LSB   = 4;

    typedef enum logic [2:0] {
        RA_BASE   = 3'd0,
        RA_POS    = 3'd1,
        RA_COLOR0 = 3'd2,
        RA_COLOR1 = 3'd3,
        RA_CTRL   = 3'd4,
        RA_GEOM   = 3'd5
    } reg_sel_e;

    typedef struct packed {
        logic              en;
        logic [OFF_W-1:0]  base;
        logic [XPOS_W-1:0] x;
        logic [YPOS_W-1:0] y;
    } cur_cfg_t;
endpackage

// File: rtl/cursor_regs.sv
`timescale 1ns/1ps
module cursor_regs
    import cursor_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [2:0]         waddr,
    input  logic [31:0]        wdata,
    input  logic               frame_start,
    output cur_cfg_t           act,
    output logic [COLOR_W-1:0] color0,
    output logic [COLOR_W-1:0] color1,
    output logic [COORD_W-1:0] disp_w,
    output logic [COORD_W-1:0] disp_last
);
    typedef struct packed {
        logic [OFF_W-1:0]   base;
        logic               lock;
        logic [XPOS_W-1:0]  x;
        logic [YPOS_W-1:0]  y;
        logic               en;
        logic [COLOR_W-1:0] c0;
        logic [COLOR_W-1:0] c1;
        logic [COORD_W-1:0] w;
        logic [COORD_W-1:0] last;
        cur_cfg_t           act;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d = q;
        if (frame_start && !q.lock) begin
            d.act.en   = q.en;
            d.act.base = q.base;
            d.act.x    = q.x;
            d.act.y    = q.y;
        end
        if (wr) begin
            case (reg_sel_e'(waddr))
                RA_BASE: begin
                    d.base = {wdata[OFF_W-1:BASE_LSB], {BASE_LSB{1'b0}}};
                    d.lock = wdata[LOCK_BIT];
                end
                RA_POS: begin
                    d.x    = wdata[16 +: XPOS_W];
                    d.y    = wdata[YPOS_W-1:0];
                    d.lock = wdata[LOCK_BIT];
                end
                RA_COLOR0: d.c0 = wdata[COLOR_W-1:0];
                RA_COLOR1: d.c1 = wdata[COLOR_W-1:0];
                RA_CTRL:   d.en = wdata[0];
                RA_GEOM: begin
                    d.w    = wdata[COORD_W-1:0];
                    d.last = wdata[31:COORD_W];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign act       = q.act;
    assign color0    = q.c0;
    assign color1    = q.c1;
    assign disp_w    = q.w;
    assign disp_last = q.last;

    // R10
    act_only_at_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(q.act));

    // R9
    lock_freezes_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && q.lock) |=> $stable(q.act));

    // R9
    lock_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (waddr == RA_POS || waddr == RA_BASE)) |=> (q.lock == $past(wdata[LOCK_BIT])));
endmodule

// File: rtl/cursor_fetch.sv
`timescale 1ns/1ps
module cursor_fetch
    import cursor_pkg::*;
#(
    parameter int MEM_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fetch_req,
    input  logic [COORD_W-1:0]   fetch_y,
    input  logic                 act_en,
    input  logic [OFF_W-1:0]     act_base,
    input  logic [YPOS_W-1:0]    act_y,
    input  logic [COORD_W-1:0]   disp_last,
    output logic                 mem_rd_en,
    output logic [OFF_W-1:0]     mem_addr,
    input  logic [MEM_W-1:0]     mem_rdata,
    output logic [LINE_BITS-1:0] line_bits,
    output logic                 line_ok,
    output logic [COORD_W-1:0]   line_y
);
    localparam int WORDS = LINE_BITS / MEM_W;
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam int STEP  = MEM_W / 8;
    localparam int ROW_W = $clog2(CUR_DIM);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

    typedef struct packed {
        logic                 busy;
        logic [IDX_W-1:0]     cnt;
        logic [OFF_W-1:0]     base;
        logic                 pend;
        logic [IDX_W-1:0]     pidx;
        logic [LINE_BITS-1:0] buf_bits;
        logic                 valid;
        logic                 show;
        logic [COORD_W-1:0]   ly;
    } fetch_t;

    fetch_t q, d;
    logic [COORD_W:0] diff;
    logic [ROW_W-1:0] row;
    logic             visible;

    always_comb begin
        diff    = {1'b0, fetch_y} - {{(COORD_W+1-YPOS_W){1'b0}}, act_y};
        row     = diff[ROW_W-1:0];
        visible = act_en && !diff[COORD_W] && (diff[COORD_W-1:ROW_W] == '0)
                  && (fetch_y <= disp_last);

        d      = q;
        d.pend = q.busy;
        d.pidx = q.cnt;
        if (q.busy) begin
            d.cnt = q.cnt + 1'b1;
            if (q.cnt == LAST_IDX) d.busy = 1'b0;
        end
        if (q.pend) begin
            d.buf_bits[q.pidx*MEM_W +: MEM_W] = mem_rdata;
            if (q.pidx == LAST_IDX) d.valid = 1'b1;
        end
        if (fetch_req) begin
            d.valid = 1'b0;
            d.pend  = 1'b0;
            d.ly    = fetch_y;
            d.show  = visible;
            d.busy  = visible;
            d.cnt   = '0;
            d.base  = act_base + OFF_W'({row, 4'b0000});
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mem_rd_en = q.busy;
    assign mem_addr  = q.base + OFF_W'(q.cnt) * OFF_W'(STEP);
    assign line_bits = q.buf_bits;
    assign line_ok   = q.valid && q.show;
    assign line_y    = q.ly;

    // R7
    read_stride_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && $past(mem_rd_en)) |-> (mem_addr == $past(mem_addr) + OFF_W'(STEP)));

    // R11
    hidden_row_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !visible) |=> !mem_rd_en);
endmodule

// File: rtl/cursor_mix.sv
`timescale 1ns/1ps
module cursor_mix
    import cursor_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pix_valid,
    input  logic [COORD_W-1:0]   pix_x,
    input  logic [COORD_W-1:0]   pix_y,
    input  logic [31:0]          pix_in,
    input  logic [XPOS_W-1:0]    act_x,
    input  logic [COLOR_W-1:0]   color0,
    input  logic [COLOR_W-1:0]   color1,
    input  logic [COORD_W-1:0]   disp_w,
    input  logic [LINE_BITS-1:0] line_bits,
    input  logic                 line_ok,
    input  logic [COORD_W-1:0]   line_y,
    output logic                 pix_out_valid,
    output logic [31:0]          pix_out
);
    localparam int COL_W = $clog2(CUR_DIM);

    typedef struct packed {
        logic        valid;
        logic [31:0] pix;
    } mix_t;

    mix_t q, d;
    logic [COORD_W:0] dx;
    logic [COL_W-1:0] col;
    logic [COL_W-1:0] bit_idx;
    logic             hit;
    logic             and_bit;
    logic             xor_bit;

    always_comb begin
        dx      = {1'b0, pix_x} - {{(COORD_W+1-XPOS_W){1'b0}}, act_x};
        col     = dx[COL_W-1:0];
        bit_idx = {col[COL_W-1:3], ~col[2:0]};
        and_bit = line_bits[{1'b0, bit_idx}];
        xor_bit = line_bits[{1'b1, bit_idx}];
        hit     = line_ok && (pix_y == line_y) && !dx[COORD_W]
                  && (dx[COORD_W-1:COL_W] == '0) && (pix_x < disp_w);

        d.valid = pix_valid;
        if (!hit)         d.pix = pix_in;
        else if (and_bit) d.pix = xor_bit ? ~pix_in : pix_in;
        else              d.pix = {8'hFF, xor_bit ? color1 : color0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pix_out_valid = q.valid;
    assign pix_out       = q.pix;

    // R2
    one_cycle_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_out_valid == $past(pix_valid));

    // R2
    passthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pix_valid) && !$past(hit)) |-> (pix_out == $past(pix_in)));

    // R3
    colour_alpha_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(hit) && !$past(and_bit)) |-> (pix_out[31:24] == 8'hFF));

    // R4
    and_plane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(hit) && $past(and_bit)) |->
        (pix_out == ($past(xor_bit) ? ~$past(pix_in) : $past(pix_in))));
endmodule

// File: rtl/cursor_overlay.sv
`timescale 1ns/1ps
module cursor_overlay
    import cursor_pkg::*;
#(
    parameter int MEM_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [2:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    input  logic               frame_start,
    input  logic               fetch_req,
    input  logic [COORD_W-1:0] fetch_y,
    input  logic               pix_valid,
    input  logic [COORD_W-1:0] pix_x,
    input  logic [COORD_W-1:0] pix_y,
    input  logic [31:0]        pix_in,
    output logic               pix_out_valid,
    output logic [31:0]        pix_out,
    output logic               mem_rd_en,
    output logic [OFF_W-1:0]   mem_addr,
    input  logic [MEM_W-1:0]   mem_rdata
);
    cur_cfg_t             act;
    logic [COLOR_W-1:0]   color0, color1;
    logic [COORD_W-1:0]   disp_w, disp_last;
    logic [LINE_BITS-1:0] line_bits;
    logic                 line_ok;
    logic [COORD_W-1:0]   line_y;

    cursor_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr          (reg_wr),
        .waddr       (reg_addr),
        .wdata       (reg_wdata),
        .frame_start (frame_start),
        .act         (act),
        .color0      (color0),
        .color1      (color1),
        .disp_w      (disp_w),
        .disp_last   (disp_last)
    );

    cursor_fetch #(.MEM_W(MEM_W)) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .fetch_req (fetch_req),
        .fetch_y   (fetch_y),
        .act_en    (act.en),
        .act_base  (act.base),
        .act_y     (act.y),
        .disp_last (disp_last),
        .mem_rd_en (mem_rd_en),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .line_bits (line_bits),
        .line_ok   (line_ok),
        .line_y    (line_y)
    );

    cursor_mix u_mix (
        .clk           (clk),
        .rst_n         (rst_n),
        .pix_valid     (pix_valid),
        .pix_x         (pix_x),
        .pix_y         (pix_y),
        .pix_in        (pix_in),
        .act_x         (act.x),
        .color0        (color0),
        .color1        (color1),
        .disp_w        (disp_w),
        .line_bits     (line_bits),
        .line_ok       (line_ok),
        .line_y        (line_y),
        .pix_out_valid (pix_out_valid),
        .pix_out       (pix_out)
    );
endmodule

// File: tb/sim_cursor_overlay.sv
`timescale 1ns/1ps
module sim_cursor_overlay;
    localparam int MEM_W = 32;
    localparam int NBYTE = MEM_W / 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        frame_start = 1'b0;
    logic        fetch_req = 1'b0;
    logic [15:0] fetch_y = '0;
    logic        pix_valid = 1'b0;
    logic [15:0] pix_x = '0, pix_y = '0;
    logic [31:0] pix_in = '0;
    logic        pix_out_valid;
    logic [31:0] pix_out;
    logic        mem_rd_en;
    logic [26:0] mem_addr;
    logic [MEM_W-1:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;
    int rd_cnt = 0;
    bit done = 0;

    // bench model of registers
    logic [26:0] s_base = '0; logic s_lock = 0; logic [13:0] s_x = '0; logic [11:0] s_y = '0;
    logic s_en = 0; logic [23:0] c0 = '0, c1 = '0; logic [15:0] hw = '0, vl = '0;
    logic a_en = 0; logic [26:0] a_base = '0; logic [13:0] a_x = '0; logic [11:0] a_y = '0;

    always #2 clk = ~clk;

    cursor_overlay #(.MEM_W(MEM_W)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .frame_start(frame_start), .fetch_req(fetch_req), .fetch_y(fetch_y),
        .pix_valid(pix_valid), .pix_x(pix_x), .pix_y(pix_y), .pix_in(pix_in),
        .pix_out_valid(pix_out_valid), .pix_out(pix_out),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] byte_at(input logic [26:0] a);
        return (a[7:0] * 8'd29) ^ a[15:8] ^ {a[19:16], a[23:20]} ^ 8'h5A;
    endfunction

    always @(posedge clk) begin
        if (mem_rd_en) begin
            rd_cnt++;
            for (int k = 0; k < NBYTE; k++) mem_rdata[8*k +: 8] <= byte_at(mem_addr + 27'(k));
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wreg(input logic [2:0] a, input logic [31:0] dat);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = dat;
        @(negedge clk);
        reg_wr = 0;
        case (a)
            3'd0: begin s_base = dat[26:0] & 27'h7FF_FFF0; s_lock = dat[31]; end
            3'd1: begin s_x = dat[29:16]; s_y = dat[11:0]; s_lock = dat[31]; end
            3'd2: c0 = dat[23:0];
            3'd3: c1 = dat[23:0];
            3'd4: s_en = dat[0];
            3'd5: begin hw = dat[15:0]; vl = dat[31:16]; end
            default: ;
        endcase
    endtask

    task automatic new_frame();
        @(negedge clk); frame_start = 1;
        @(negedge clk); frame_start = 0;
        if (!s_lock) begin a_en = s_en; a_base = s_base; a_x = s_x; a_y = s_y; end
    endtask

    function automatic bit row_drawn(input int y);
        return a_en && y >= int'(a_y) && y < int'(a_y) + 64 && y <= int'(vl);
    endfunction

    function automatic void predict(input int x, input int y, input logic [31:0] pin,
                                    output logic [31:0] r, output string tag);
        int row, col; logic [26:0] ad; logic [7:0] ab, xb; logic abit, xbit;
        r = pin; tag = "R2";
        if (!a_en) begin tag = "R10"; return; end
        row = y - int'(a_y); col = x - int'(a_x);
        if (col < 0 || col >= 64) return;
        if (!row_drawn(y)) begin tag = "R5"; return; end
        if (x >= int'(hw)) begin tag = "R6"; return; end
        ad = a_base + 27'(row * 16);
        ab = byte_at(ad + 27'(col / 8));
        xb = byte_at(ad + 27'(8 + col / 8));
        abit = ab[7 - col % 8]; xbit = xb[7 - col % 8];
        if (abit) begin tag = "R4"; if (xbit) r = ~pin; end
        else begin tag = "R3"; r = {8'hFF, xbit ? c1 : c0}; end
    endfunction

    task automatic run_line(input int y, input int nx, input string ctx, input logic [7:0] salt);
        logic [31:0] pe; string ptag; int exp_rd;
        rd_cnt = 0;
        @(negedge clk); fetch_req = 1; fetch_y = 16'(y);
        @(negedge clk); fetch_req = 0;
        repeat (8) @(negedge clk);
        exp_rd = row_drawn(y) ? 128 / MEM_W : 0;
        // R7 / R11: read count per line
        check(rd_cnt == exp_rd, row_drawn(y) ? "R7 read count" : "R11 no reads",
              64'(rd_cnt), 64'(exp_rd));
        pe = '0; ptag = "";
        for (int x = 0; x <= nx; x++) begin
            @(negedge clk);
            if (x > 0)
                check(pix_out_valid === 1'b1 && pix_out === pe, {ptag, " ", ctx},
                      {31'd0, pix_out_valid, pix_out}, {32'd1, pe});
            if (x < nx) begin
                pix_valid = 1; pix_x = 16'(x); pix_y = 16'(y);
                pix_in = {8'(y), 8'(x), ~8'(x), 8'h3C ^ salt};
                predict(x, y, pix_in, pe, ptag);
            end else begin
                pix_valid = 0;
            end
        end
        @(negedge clk);
        check(pix_out_valid == 1'b0, "R2 valid drop", 64'(pix_out_valid), 64'd0);
    endtask

    task automatic run_frame(input string ctx, input logic [7:0] salt);
        for (int y = 0; y < 45; y++) run_line(y, 104, ctx, salt);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(pix_out_valid == 0 && mem_rd_en == 0 && pix_out == 0, "R1 in reset",
              {30'd0, pix_out_valid, mem_rd_en, pix_out}, 64'd0);
        rst_n = 1;
        @(negedge clk);
        check(pix_out_valid == 0 && mem_rd_en == 0 && pix_out == 0, "R1 after reset",
              {30'd0, pix_out_valid, mem_rd_en, pix_out}, 64'd0);

        // R8: geometry width 100, last row 40; colours with junk upper byte
        wreg(3'd5, {16'd40, 16'd100});
        wreg(3'd2, 32'hAB12_3456);
        wreg(3'd3, 32'hCD65_4321);
        wreg(3'd4, 32'h0000_0001);
        // R8: base with junk low nibble and bits 30:27
        wreg(3'd0, 32'h7800_123F);
        // R8: position x=90 y=5 with junk bits 30 and 15:12
        wreg(3'd1, 32'h405A_7005);
        new_frame();
        run_frame("R8 frame1 clip right", 8'h01);

        // R9: move with lock set through position bit 31
        wreg(3'd1, 32'h8003_0014);
        new_frame();
        run_frame("R9 locked by position", 8'h02);

        // R10: unlock, move to corner, then a mid-frame move
        wreg(3'd0, 32'h0000_0800);
        wreg(3'd1, 32'h0000_0000);
        new_frame();
        wreg(3'd1, 32'h0032_001E);
        run_frame("R10 mid-frame write", 8'h03);

        // R9: lock through base bit 31
        wreg(3'd0, 32'h8000_3000);
        new_frame();
        run_frame("R9 locked by base", 8'h04);

        // R10 / R11: disable and unlock
        wreg(3'd4, 32'h0000_0000);
        wreg(3'd1, 32'h0032_001E);
        new_frame();
        run_frame("R11 disabled", 8'h05);

        // R5 / R6: enable at x=50 y=30, crossing the last row and width
        wreg(3'd4, 32'h0000_0001);
        wreg(3'd2, 32'h0000_FF00);
        wreg(3'd3, 32'h0012_0000);
        new_frame();
        run_frame("R5 R6 bottom right", 8'h06);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule